// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a multi-channel DMA engine. A simple request/response port reaches a small set of global words (a control word, two interrupt mask words and two interrupt source words) and a repeated group of eight words per channel. Each group holds a control/status word, a transfer size, source and destination addresses, a mask for each address, a descriptor pointer and a software pointer. The transfer engine is a separate block. It receives a one-cycle start pulse when software enables a channel and a one-cycle cancel pulse when software writes the enable bit as zero. It reports events back through per-channel flag inputs.

Each status word combines software-writable control bits with sticky event flags. The flags are raised by the engine and cleared as a side effect of software reading the status word. Misaligned accesses, unused global offsets and channels beyond the configured count are refused: the error output is raised for one cycle, and such an access changes no state.

Top module: `dma_reg_bank`

## Requirements
- R1: After reset every register reads zero, except the source-mask and destination-mask words of every channel, which read 0xFFFFFFFC.
- R2: The global words at offsets 0x04, 0x08, 0x0C and 0x10 (two mask words, two source words) store and return all 32 written bits.
- R3: A write to the global control word at offset 0x00 is accepted without error. The word always reads back zero.
- R4: An access whose address has either of its two low bits set is refused. The error output is high, the read data is zero and no register changes.
- R5: An access to global offsets 0x14, 0x18 or 0x1C, or to a channel group whose index is NCH or above, is refused and has no effect. It reads zero with the error output high.
- R6: Channel c's group starts at 0x20 + c*0x20. Its words, at steps of 4, are status, size, source, source mask, destination, destination mask, descriptor and software pointer. The last seven store all 32 written bits.
- R7: A write to a status word changes only bits 7:0, where bit 0 is the channel enable. Bits 11:8 are not affected by the write, and bits 31:12 always read zero.
- R8: Flag input bit c*4+k sets status bit 8+k of channel c. A read of the status word returns the current value and then clears bits 11:8. A flag set in the same cycle as the read survives.
- R9: A status write with data bit 0 set, while the stored enable is 0, raises start bit c for exactly one cycle. The pulse appears together with the response. If enable is already 1, no pulse is raised.
- R10: A status write with data bit 0 clear raises cancel bit c for one cycle, whatever the previous enable value.
- R11: Every request cycle produces rsp_valid exactly one cycle later, with rsp_err in the same cycle. Write responses and refused accesses carry zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_wdata | input | 32 | Write data |
| flag_set | input | NCH*4 | Sticky flag set strobes, four per channel |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was refused |
| rsp_rdata | output | 32 | Read data |
| start_o | output | NCH | One-cycle transfer start per channel |
| cancel_o | output | NCH | One-cycle transfer cancel per channel |

## Verification
A wrong stored bit shows up at rsp_rdata on the next read of that word, one cycle after the request. The bench therefore follows random writes with random reads of the whole map against a model. A wrong stored enable bit shows up as a missing or extra start pulse, in the response cycle of the next status write. Sticky flag errors are observed as a stale or lost flag on a second status read, issued right after the first.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
    localparam int          WORD_W    = 32;
    localparam int          STRIDE_SH = 5;            // 0x20 bytes per channel group
    localparam int          CH_BASE   = 32'h20;
    localparam int          NGLOB     = 5;            // defined global words
    localparam int          FLAG_N    = 4;
    localparam int          CSR_W     = 12;
    localparam logic [31:0] MASK_RST  = 32'hFFFF_FFFC;
    localparam logic [7:0]  CSR_WMASK = 8'hFF;

    typedef enum logic [2:0] {
        CR_STAT = 3'd0, CR_SIZE = 3'd1, CR_SRC  = 3'd2, CR_SMSK = 3'd3,
        CR_DST  = 3'd4, CR_DMSK = 3'd5, CR_DESC = 3'd6, CR_SWP  = 3'd7
    } ch_reg_e;

    typedef struct packed {
        logic [CSR_W-1:0]  stat;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] smsk;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] dmsk;
        logic [WORD_W-1:0] desc;
        logic [WORD_W-1:0] swp;
        logic              start;
        logic              cancel;
    } ch_state_t;

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] msk_a;
        logic [WORD_W-1:0] msk_b;
        logic [WORD_W-1:0] src_a;
        logic [WORD_W-1:0] src_b;
    } glob_state_t;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_reg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 4,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CHF_W = ADDR_W - STRIDE_SH
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_glob,
    output logic [2:0]        g_idx,
    output logic [CH_W-1:0]   ch_idx,
    output logic [2:0]        r_idx,
    output logic              legal
);
    logic [ADDR_W-1:0] rel;
    logic [CHF_W-1:0]  ch_full;
    logic              aligned;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        is_glob = (addr < ADDR_W'(CH_BASE));
        g_idx   = addr[4:2];
        rel     = addr - ADDR_W'(CH_BASE);
        ch_full = rel[ADDR_W-1:STRIDE_SH];
        ch_idx  = ch_full[CH_W-1:0];
        r_idx   = rel[4:2];
        if (!aligned)
            legal = 1'b0;
        else if (is_glob)
            legal = (g_idx < 3'(NGLOB));
        else
            legal = (ch_full < CHF_W'(NCH));
    end
endmodule

// File: rtl/dma_reg_channel.sv
module dma_reg_channel
    import dma_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [FLAG_N-1:0] flag_set,
    output logic [WORD_W-1:0] rdata,
    output logic              start_o,
    output logic              cancel_o
);
    ch_state_t q, d;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.cancel = 1'b0;
        if (wr_en) begin
            unique case (ch_reg_e'(idx))
                CR_STAT: begin
                    d.stat[7:0] = (q.stat[7:0] & ~CSR_WMASK) | (wdata[7:0] & CSR_WMASK);
                    d.start     = wdata[0] & ~q.stat[0];
                    d.cancel    = ~wdata[0];
                end
                CR_SIZE: d.size = wdata;
                CR_SRC:  d.src  = wdata;
                CR_SMSK: d.smsk = wdata;
                CR_DST:  d.dst  = wdata;
                CR_DMSK: d.dmsk = wdata;
                CR_DESC: d.desc = wdata;
                CR_SWP:  d.swp  = wdata;
                default: ;
            endcase
        end
        if (rd_en && ch_reg_e'(idx) == CR_STAT)
            d.stat[CSR_W-1:8] = '0;
        d.stat[CSR_W-1:8] = d.stat[CSR_W-1:8] | flag_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.smsk <= MASK_RST;
            q.dmsk <= MASK_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (ch_reg_e'(idx))
            CR_STAT: rdata = {{(WORD_W-CSR_W){1'b0}}, q.stat};
            CR_SIZE: rdata = q.size;
            CR_SRC:  rdata = q.src;
            CR_SMSK: rdata = q.smsk;
            CR_DST:  rdata = q.dst;
            CR_DMSK: rdata = q.dmsk;
            CR_DESC: rdata = q.desc;
            CR_SWP:  rdata = q.swp;
            default: rdata = '0;
        endcase
    end

    assign start_o  = q.start;
    assign cancel_o = q.cancel;

    assert_start_sets_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> q.stat[0]);
    assert_cancel_clears_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cancel |-> !q.stat[0]);
    assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.start && q.cancel));
    assert_read_clears_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == 3'd0 && flag_set == '0) |=> q.stat[CSR_W-1:8] == '0);
    assert_flags_not_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set == '0 && !(rd_en && idx == 3'd0)) |=> $stable(q.stat[CSR_W-1:8]));
endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
    import dma_reg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    input  logic [NCH*4-1:0]      flag_set,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    output logic [NCH-1:0]        start_o,
    output logic [NCH-1:0]        cancel_o
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic              is_glob, legal;
    logic [2:0]        g_idx, r_idx;
    logic [CH_W-1:0]   ch_idx;
    logic [WORD_W-1:0] ch_rdata [NCH];
    logic [NCH-1:0]    ch_wr, ch_rd;

    dma_reg_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .addr(req_addr), .is_glob(is_glob), .g_idx(g_idx),
        .ch_idx(ch_idx), .r_idx(r_idx), .legal(legal)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel      = req_valid && legal && !is_glob && (ch_idx == CH_W'(c));
        assign ch_wr[c] = sel && req_write;
        assign ch_rd[c] = sel && !req_write;
        dma_reg_channel u_ch (
            .clk(clk), .rst_n(rst_n), .wr_en(ch_wr[c]), .rd_en(ch_rd[c]),
            .idx(r_idx), .wdata(req_wdata), .flag_set(flag_set[c*4 +: 4]),
            .rdata(ch_rdata[c]), .start_o(start_o[c]), .cancel_o(cancel_o[c])
        );
    end

    glob_state_t q, d;

    always_comb begin
        d           = q;
        d.rsp_valid = req_valid;
        d.rsp_err   = req_valid && !legal;
        d.rdata     = '0;
        if (req_valid && legal) begin
            if (is_glob) begin
                if (req_write) begin
                    unique case (g_idx)
                        3'd1:    d.msk_a = req_wdata;
                        3'd2:    d.msk_b = req_wdata;
                        3'd3:    d.src_a = req_wdata;
                        3'd4:    d.src_b = req_wdata;
                        default: ;  // control word: accepted, no effect
                    endcase
                end else begin
                    unique case (g_idx)
                        3'd1:    d.rdata = q.msk_a;
                        3'd2:    d.rdata = q.msk_b;
                        3'd3:    d.rdata = q.src_a;
                        3'd4:    d.rdata = q.src_b;
                        default: d.rdata = '0;
                    endcase
                end
            end else if (!req_write) begin
                d.rdata = ch_rdata[ch_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_err   = q.rsp_err;
    assign rsp_rdata = q.rdata;

    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_without_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_err_has_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    assert_pulse_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, cancel_o}));
endmodule

// File: tb/dma_reg_bank_tb.sv
`timescale 1ns/1ps
module dma_reg_bank_tb;
    localparam int ADDR_W = 12;
    localparam int NCH    = 4;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [NCH*4-1:0]  flag_set = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NCH-1:0]    start_o, cancel_o;

    always #2 clk = ~clk;

    dma_reg_bank #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .flag_set(flag_set),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .start_o(start_o), .cancel_o(cancel_o)
    );

    int          n_checks = 0, n_errs = 0;
    logic [31:0] m_glob [5];
    logic [31:0] m_ch [NCH][8];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int g = 0; g < 5; g++) m_glob[g] = 0;
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 8; r++)
                m_ch[c][r] = (r == 3 || r == 5) ? 32'hFFFF_FFFC : 32'h0;
    endfunction

    // classify: 0 global legal, 1 channel legal, 2 refused
    function automatic int kind(logic [ADDR_W-1:0] a);
        if (a[1:0] != 0) return 2;
        if (a < 12'h20) return (a < 12'h14) ? 0 : 2;
        if (((int'(a) - 32) / 32) >= NCH) return 2;
        return 1;
    endfunction

    task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [31:0] wd, input logic [NCH*4-1:0] fl,
                          input string req);
        int k, c, r;
        logic [31:0] exp_rd;
        logic [NCH-1:0] exp_st, exp_cn;
        k = kind(a);
        c = (int'(a) - 32) / 32;
        r = (int'(a) % 32) / 4;
        exp_rd = 0; exp_st = 0; exp_cn = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; flag_set = fl;
        if (k == 0) begin
            if (wr) begin if (a != 0) m_glob[a/4] = wd; end
            else exp_rd = m_glob[a/4];
        end else if (k == 1) begin
            if (wr) begin
                if (r == 0) begin
                    exp_st[c] = wd[0] & ~m_ch[c][0][0];
                    exp_cn[c] = ~wd[0];
                    m_ch[c][0][7:0] = wd[7:0];
                end else m_ch[c][r] = wd;
            end else begin
                exp_rd = m_ch[c][r];
                if (r == 0) m_ch[c][0][11:8] = 0;
            end
        end
        for (int i = 0; i < NCH; i++) m_ch[i][0][11:8] |= fl[i*4 +: 4];
        @(negedge clk);
        req_valid = 0; flag_set = 0;
        check({req, " valid (R11)"}, {31'b0, rsp_valid}, 1);
        check({req, " err (R4/R5)"}, {31'b0, rsp_err}, {31'b0, (k == 2)});
        check({req, " rdata"}, rsp_rdata, exp_rd);
        check({req, " start (R9)"}, 32'(start_o), 32'(exp_st));
        check({req, " cancel (R10)"}, 32'(cancel_o), 32'(exp_cn));
    endtask

    function automatic logic [ADDR_W-1:0] rand_addr();
        int s = $urandom % 10;
        if (s < 2) return ADDR_W'(($urandom % 5) * 4);
        if (s < 8) return ADDR_W'(32 + ($urandom % NCH) * 32 + ($urandom % 8) * 4);
        if (s == 8) return ADDR_W'($urandom % 4096);
        return ADDR_W'(32 + NCH * 32 + ($urandom % 64) * 4);
    endfunction

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errs++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values of the whole map
        for (int g = 0; g < 5; g++) access(0, ADDR_W'(g * 4), 0, 0, "R1 glob");
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 8; r++) access(0, ADDR_W'(32 + c * 32 + r * 4), 0, 0, "R1 chan");
        // R2, R3
        access(1, 12'h004, 32'hDEAD_BEEF, 0, "R2 wr"); access(0, 12'h004, 0, 0, "R2 rd");
        access(1, 12'h010, 32'hFFFF_FFFF, 0, "R2 wr"); access(0, 12'h010, 0, 0, "R2 rd");
        access(1, 12'h000, 32'hFFFF_FFFF, 0, "R3 wr"); access(0, 12'h000, 0, 0, "R3 rd");
        // R4, R5: refused writes leave state
        access(1, 12'h026, 32'h1234_5678, 0, "R4 wr"); access(0, 12'h024, 0, 0, "R4 rd");
        access(1, 12'h018, 32'h1, 0, "R5 glob");   access(0, 12'h01C, 0, 0, "R5 glob rd");
        access(1, ADDR_W'(32 + NCH * 32), 32'h1, 0, "R5 chan"); access(0, ADDR_W'(32 + NCH * 32), 0, 0, "R5 rd");
        // R6, R7: status write mask
        access(1, 12'h02C, 32'h0, 0, "R6 wr"); access(0, 12'h02C, 0, 0, "R6 rd");
        access(1, 12'h040, 32'hFFFF_FF00, 0, "R7 wr"); access(0, 12'h040, 0, 0, "R7 rd");
        // R9/R10: start once, no second start, cancel
        access(1, 12'h060, 32'h1, 0, "R9 start");
        access(1, 12'h060, 32'h3, 0, "R9 again");
        access(1, 12'h060, 32'h0, 0, "R10 cancel");
        access(1, 12'h060, 32'h0, 0, "R10 cancel2");
        // R8: flags, clear on read, set wins during read
        access(0, 12'h000, 0, 16'h5A3C, "R8 set");
        access(0, 12'h020, 0, 0, "R8 rd1"); access(0, 12'h020, 0, 0, "R8 rd2");
        access(0, 12'h040, 0, 16'h0090, "R8 race"); access(0, 12'h040, 0, 0, "R8 race2");
        access(1, 12'h080, 32'h0, 0, "R7 flags kept"); access(0, 12'h080, 0, 0, "R7 flags rd");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [NCH*4-1:0] fl;
            fl = ($urandom % 8 == 0) ? (NCH*4)'($urandom) : '0;
            access(($urandom % 2) == 1, rand_addr(), $urandom, fl, "R6 rand");
        end
        // R11: idle cycle has no response
        @(negedge clk);
        check("R11 idle", {31'b0, rsp_valid}, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule